// File: doc/BRIEF.md
# Independent Key-Locked Watchdog

This block is a watchdog timer with its own slow clock. A 12-bit down-counter in the slow domain is loaded from a reload value and decrements once per divided slow tick. When the counter has reached zero and one more tick arrives, the block raises a one-cycle reset request and reloads the counter.

Software in the bus clock domain works through a small register file. A key register accepts three 16-bit magic words: one grants write access to the divider and reload registers, one restarts the count, and one enables the watchdog. Once the watchdog is enabled, nothing can disable it again. Each accepted divider or reload write raises a busy flag. The flag stays set until the value has crossed into the slow domain over a toggle handshake with two-flop synchronizers. A read-only register shows the live count, passed across domains in Gray code.

Top module: `wdg_indep`

## Requirements
- R1: After reset, the divider register (offset 1) reads 0, the reload register (offset 2) reads 0xFFF, the status register (offset 3) reads 0, the count register (offset 4) reads 0xFFF, and reset_req_o is low.
- R2: The key register is at offset 0. Writing 0x5555 to it grants write access. Writing any other value to it removes write access. While access is not granted, writes to offsets 1 and 2 leave those registers unchanged.
- R3: A divider or reload write that is accepted reads back on the next bus cycle. The divider field is bits 2:0, and any value above 6 is stored as 6. The reload field is bits 11:0.
- R4: Status bit 0 (divider busy) or bit 1 (reload busy) is set on the bus cycle after an accepted write to that register. The bit clears once the slow domain has taken the value. A write to a register whose busy bit is set is ignored.
- R5: Writing 0xAAAA to the key register loads the down-counter from the reload value and removes write access.
- R6: Writing 0xCCCC to the key register enables the watchdog. Before that, reset_req_o never rises.
- R7: Once enabled, the watchdog keeps issuing reset requests whatever is written afterwards.
- R8: With divider field P and reload value R, and no restart, reset_req_o rises every (R+1)·2^(P+2) slow cycles. Each pulse lasts exactly one slow cycle.
- R9: Restarts written more often than the timeout keep reset_req_o low.
- R10: While the watchdog runs, the count register reads a value no larger than the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tick_clk_i | input | 1 | Slow independent watchdog clock |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| reset_req_o | output | 1 | Reset request pulse, slow domain |

## Verification
Register read-back and the setting of a busy bit are due one bus cycle after the write, so the bench samples them on the falling edge after the write edge. Busy clearing and count updates cross two synchronizer stages in each direction, so the bench polls them within a fixed bound instead of expecting a fixed cycle. The reset-request period is measured as the distance in slow cycles between successive pulses, sampled on falling slow-clock edges. The bench only accepts the third pulse after any configuration change, so the crossing latency cannot move the expected value of (R+1)·2^(P+2).

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DW     = 16;
  localparam int CW     = 12;
  localparam int PW     = 3;
  localparam int AW     = 3;
  localparam int PR_MAX = 6;
  localparam int DIV_W  = PR_MAX + 2;

  localparam logic [DW-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [DW-1:0] KEY_KICK   = 16'hAAAA;
  localparam logic [DW-1:0] KEY_START  = 16'hCCCC;

  localparam logic [AW-1:0] A_KEY = 3'd0;
  localparam logic [AW-1:0] A_PRE = 3'd1;
  localparam logic [AW-1:0] A_RLD = 3'd2;
  localparam logic [AW-1:0] A_STS = 3'd3;
  localparam logic [AW-1:0] A_CNT = 3'd4;

  localparam logic [CW-1:0] CNT_RST  = '1;
  localparam logic [CW-1:0] GRAY_RST = CNT_RST ^ (CNT_RST >> 1);
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int            W   = 1,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ack_pr_i,
  input  logic          ack_rl_i,
  input  logic [CW-1:0] cnt_gray_i,
  output logic [PW-1:0] pr_o,
  output logic [CW-1:0] rl_o,
  output logic          pr_tgl_o,
  output logic          rl_tgl_o,
  output logic          kick_tgl_o,
  output logic          start_o
);
  logic          unlock_q, start_q, pr_tgl_q, rl_tgl_q, kick_tgl_q;
  logic [PW-1:0] pr_q;
  logic [CW-1:0] rl_q;
  logic [1:0]    ack_s;
  logic [CW-1:0] gray_s, cnt_bin;
  logic          pr_busy, rl_busy, key_wr, pr_wr, rl_wr;
  logic [PW-1:0] pr_new;

  wdg_sync #(.W(2), .RST(2'b00)) u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({ack_rl_i, ack_pr_i}), .q_o(ack_s)
  );
  wdg_sync #(.W(CW), .RST(GRAY_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_gray_i), .q_o(gray_s)
  );

  assign pr_busy = pr_tgl_q ^ ack_s[0];
  assign rl_busy = rl_tgl_q ^ ack_s[1];
  assign key_wr  = we_i && (addr_i == A_KEY);
  assign pr_wr   = we_i && (addr_i == A_PRE) && unlock_q && !pr_busy;
  assign rl_wr   = we_i && (addr_i == A_RLD) && unlock_q && !rl_busy;
  assign pr_new  = (wdata_i[PW-1:0] > PW'(PR_MAX)) ? PW'(PR_MAX) : wdata_i[PW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q   <= 1'b0;
      start_q    <= 1'b0;
      pr_tgl_q   <= 1'b0;
      rl_tgl_q   <= 1'b0;
      kick_tgl_q <= 1'b0;
      pr_q       <= '0;
      rl_q       <= CNT_RST;
    end else begin
      if (key_wr) begin
        unlock_q <= (wdata_i == KEY_UNLOCK);
        if (wdata_i == KEY_KICK)  kick_tgl_q <= ~kick_tgl_q;
        if (wdata_i == KEY_START) start_q    <= 1'b1;
      end
      if (pr_wr) begin
        pr_q     <= pr_new;
        pr_tgl_q <= ~pr_tgl_q;
      end
      if (rl_wr) begin
        rl_q     <= wdata_i[CW-1:0];
        rl_tgl_q <= ~rl_tgl_q;
      end
    end
  end

  always_comb begin
    cnt_bin[CW-1] = gray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) cnt_bin[i] = cnt_bin[i+1] ^ gray_s[i];
  end

  always_comb begin
    case (addr_i)
      A_PRE:   rdata_o = DW'(pr_q);
      A_RLD:   rdata_o = DW'(rl_q);
      A_STS:   rdata_o = DW'({rl_busy, pr_busy});
      A_CNT:   rdata_o = DW'(cnt_bin);
      default: rdata_o = '0;
    endcase
  end

  assign pr_o       = pr_q;
  assign rl_o       = rl_q;
  assign pr_tgl_o   = pr_tgl_q;
  assign rl_tgl_o   = rl_tgl_q;
  assign kick_tgl_o = kick_tgl_q;
  assign start_o    = start_q;

  assert_locked_pre_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_PRE && !unlock_q) |=> $stable(pr_q));
  assert_locked_rld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_RLD && !unlock_q) |=> $stable(rl_q));
  assert_busy_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_wr |=> pr_busy);
  assert_start_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> start_q);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          kick_tgl_i,
  input  logic          pr_tgl_i,
  input  logic          rl_tgl_i,
  input  logic [PW-1:0] pr_i,
  input  logic [CW-1:0] rl_i,
  output logic          ack_pr_o,
  output logic          ack_rl_o,
  output logic [CW-1:0] cnt_gray_o,
  output logic          reset_req_o
);
  logic [3:0]       s;
  logic             ack_pr_q, ack_rl_q, kick_q, en_q, req_q;
  logic [PW-1:0]    pr_s;
  logic [CW-1:0]    rl_s, cnt_q, gray_q;
  logic [DIV_W-1:0] div_q, div_lim;
  logic             tick, kick_new, start_new;

  wdg_sync #(.W(4), .RST(4'b0000)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({rl_tgl_i, pr_tgl_i, kick_tgl_i, start_i}), .q_o(s)
  );

  assign div_lim   = DIV_W'((32'd4 << pr_s) - 32'd1);
  assign tick      = en_q && (div_q == div_lim);
  assign kick_new  = s[1] ^ kick_q;
  assign start_new = s[0] && !en_q;

  // config capture; ack toggle doubles as edge history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_pr_q <= 1'b0;
      ack_rl_q <= 1'b0;
      pr_s     <= '0;
      rl_s     <= CNT_RST;
    end else begin
      ack_pr_q <= s[2];
      ack_rl_q <= s[3];
      if (s[2] ^ ack_pr_q) pr_s <= pr_i;
      if (s[3] ^ ack_rl_q) rl_s <= rl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_q <= 1'b0;
      en_q   <= 1'b0;
      req_q  <= 1'b0;
      div_q  <= '0;
      cnt_q  <= CNT_RST;
      gray_q <= GRAY_RST;
    end else begin
      kick_q <= s[1];
      req_q  <= 1'b0;
      gray_q <= cnt_q ^ (cnt_q >> 1);
      if (start_new) begin
        en_q  <= 1'b1;
        cnt_q <= rl_s;
        div_q <= '0;
      end else if (kick_new) begin
        cnt_q <= rl_s;
        div_q <= '0;
      end else if (en_q) begin
        if (tick) begin
          div_q <= '0;
          if (cnt_q == '0) begin
            req_q <= 1'b1;
            cnt_q <= rl_s;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign ack_pr_o    = ack_pr_q;
  assign ack_rl_o    = ack_rl_q;
  assign cnt_gray_o  = gray_q;
  assign reset_req_o = req_q;

  assert_req_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_req_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> en_q);
  assert_en_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  assert_div_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (div_q <= div_lim || $changed(pr_s)));
endmodule

// File: rtl/wdg_indep.sv
module wdg_indep
  import wdg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          reset_req_o
);
  logic          ack_pr, ack_rl, pr_tgl, rl_tgl, kick_tgl, start;
  logic [PW-1:0] pr;
  logic [CW-1:0] rl, cnt_gray;

  wdg_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_pr_i(ack_pr), .ack_rl_i(ack_rl),
    .cnt_gray_i(cnt_gray), .pr_o(pr), .rl_o(rl), .pr_tgl_o(pr_tgl),
    .rl_tgl_o(rl_tgl), .kick_tgl_o(kick_tgl), .start_o(start)
  );

  wdg_core u_core (
    .clk_i(tick_clk_i), .rst_ni(rst_ni), .start_i(start), .kick_tgl_i(kick_tgl),
    .pr_tgl_i(pr_tgl), .rl_tgl_i(rl_tgl), .pr_i(pr), .rl_i(rl),
    .ack_pr_o(ack_pr), .ack_rl_o(ack_rl), .cnt_gray_o(cnt_gray),
    .reset_req_o(reset_req_o)
  );
endmodule

// File: tb/sim_wdg_indep.sv
module sim_wdg_indep;
  logic        clk = 0, sclk = 0, rst_n = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0;
  wire  [15:0] rdata;
  wire         req;

  always #10 clk = ~clk;
  always #35 sclk = ~sclk;

  wdg_indep u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_clk_i(sclk), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .reset_req_o(req)
  );

  int total = 0, bad = 0;
  int scyc = 0, pulses = 0, last_stamp = 0, interval = 0, width_bad = 0;
  bit prev_req = 0;
  // reference model of bus-visible config
  int m_pr = 0, m_rl = 'hFFF;
  bit m_unlock = 0, m_bpr = 0, m_brl = 0;

  // slow-domain monitor: pulse stamps in slow cycles
  always @(negedge sclk) begin
    scyc++;
    if (req) begin
      if (prev_req) width_bad++;
      else begin
        pulses++;
        interval = scyc - last_stamp;
        last_stamp = scyc;
      end
    end
    prev_req = req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
    if (a == 0) m_unlock = (d == 16'h5555);
    else if (a == 1 && m_unlock && !m_bpr) begin m_pr = (d[2:0] > 6) ? 6 : int'(d[2:0]); m_bpr = 1; end
    else if (a == 2 && m_unlock && !m_brl) begin m_rl = int'(d[11:0]); m_brl = 1; end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic check_cfg(input string tag);
    int v;
    rd(3'd1, v); chk(v == m_pr, tag, v, m_pr);
    rd(3'd2, v); chk(v == m_rl, tag, v, m_rl);
    rd(3'd3, v); chk(v == {30'd0, m_brl, m_bpr}, tag, v, {30'd0, m_brl, m_bpr});
  endtask

  task automatic wait_idle;
    int v = 1;
    for (int i = 0; i < 200 && v != 0; i++) rd(3'd3, v);
    chk(v == 0, "R4 busy clear", v, 0);
    m_bpr = 0; m_brl = 0;
  endtask

  task automatic wait_pulses(input int n, output bit ok);
    int tgt = pulses + n;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pulses >= tgt) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, p0;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check_cfg("R1 reset cfg");
    rd(3'd4, v); chk(v == 'hFFF, "R1 reset count", v, 'hFFF);
    chk(req == 0, "R1 reset req", req, 0);

    // R2 locked writes ignored; non-unlock key relocks
    wr(3'd1, 16'd3);
    check_cfg("R2 locked divider");
    wr(3'd0, 16'h5555);
    wr(3'd0, 16'h1234);
    wr(3'd2, 16'd9);
    check_cfg("R2 relocked reload");

    // R3 clamp and readback, R4 busy set
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'd7);
    rd(3'd1, v); chk(v == 6, "R3 clamp", v, 6);
    rd(3'd3, v); chk(v == 1, "R4 divider busy", v, 1);
    wait_idle;
    wr(3'd1, 16'd1);
    check_cfg("R3 divider readback");
    wait_idle;

    // R4 write while busy ignored
    wr(3'd2, 16'd5);
    wr(3'd2, 16'd8);
    check_cfg("R4 ignore while busy");
    wait_idle;

    // R5 reload key loads counter and relocks
    wr(3'd0, 16'hAAAA);
    wr(3'd1, 16'd3);
    check_cfg("R5 relock");
    repeat (40) @(negedge clk);
    rd(3'd4, v); chk(v == 5, "R5 counter loaded", v, 5);

    // R6 nothing before start
    repeat (600) @(negedge clk);
    chk(pulses == 0, "R6 no req before start", pulses, 0);

    // R8 period: (5+1)*8
    wr(3'd0, 16'hCCCC);
    wait_pulses(3, ok);
    chk(ok, "R8 pulses seen", ok, 1);
    chk(interval == 48, "R8 period P1 R5", interval, 48);

    // R10 live count bounded by reload
    for (int i = 0; i < 10; i++) begin
      rd(3'd4, v); chk(v <= 5, "R10 count bound", v, 5);
      repeat (3) @(negedge clk);
    end

    // R9 frequent restarts hold off reset
    wr(3'd0, 16'hAAAA);
    repeat (20) @(negedge clk);
    p0 = pulses;
    for (int i = 0; i < 30; i++) begin
      wr(3'd0, 16'hAAAA);
      repeat (40) @(negedge clk);
    end
    chk(pulses == p0, "R9 kicks hold off", pulses, p0);

    // R7 no write disables
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h1234);
    wr(3'd0, 16'hCCCC);
    wr(3'd0, 16'h5555);
    wait_pulses(2, ok);
    chk(ok, "R7 still running", ok, 1);

    // R8 period at largest divider: (2+1)*256
    wr(3'd1, 16'd6);
    wait_idle;
    wr(3'd2, 16'd2);
    wait_idle;
    check_cfg("R3 new config");
    wr(3'd0, 16'hAAAA);
    wait_pulses(3, ok);
    chk(ok, "R8 pulses seen P6", ok, 1);
    chk(interval == 768, "R8 period P6 R2", interval, 768);
    chk(width_bad == 0, "R8 pulse width", width_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule